// File: doc/BRIEF.md
# CPU Exception Entry Controller

This block turns fault requests raised by the pipeline of a 32-bit core with 16-bit instructions into one exception entry. Each cycle it looks at the requests and at the core state that goes with them: PC, status register, general register 15, vector base, delay-slot flag, privilege bit and FPU-enable bit. It picks the one cause that wins, then loads the register file at the next clock edge. That register file holds the values the core must save, the event code, the handler address, the following fetch address, the handler status word and the trap value.

A fault raised by the instruction in a branch delay slot is reported against the branch that owns the slot. The saved PC is moved back one instruction (2 bytes), and a clear strobe tells the pipeline to drop its delay-slot flag. Undefined and privilege faults use a separate event code when they occur in a slot, and so do FPU-disabled faults. A single-cycle done pulse goes with every entry so that the pipeline can flush.

Top module: `exc_entry_ctrl`

## Requirements
- R1: While rst_n is low, and in the first cycle after it rises, every output is zero.
- R2: An entry that is not a trap and not in a delay slot loads these values one clock after the request: saved_pc equals cur_pc, saved_sr equals cur_sr and saved_r15 equals cur_r15.
- R3: When in_slot is set for the cycle of the request, saved_pc is cur_pc minus 2 and slot_clr pulses together with ent_done.
- R4: A request raises an illegal-instruction entry in two cases: req_undef is set, or req_priv_op is set while priv_mode is 0. The event code is 0x1A0 in a delay slot and 0x180 otherwise. If req_priv_op is set while priv_mode is 1, no entry occurs.
- R5: If req_fpu_op is set while fpu_en is 0, an entry occurs with code 0x820 in a slot and 0x800 otherwise. If fpu_en is 1, no entry occurs.
- R6: An access with acc_valid set is misaligned in two cases: acc_long is 0 (16-bit) and acc_off[0] is set, or acc_long is 1 (32-bit) and acc_off[1:0] is nonzero. A misaligned read enters with code 0x0E0 and a misaligned write (acc_wr=1) with code 0x100. An aligned access causes no entry.
- R7: A trap outside a slot enters with code 0x160. It loads trap_val with trap_imm shifted left by 2 and saves cur_pc plus 2. A trap inside a slot instead enters as a slot-illegal fault (0x1A0) and leaves trap_val unchanged.
- R8: new_pc is vbr+0x400 for a TLB miss, whose event code is taken from tlb_code, and vbr+0x100 for all other causes. next_pc is new_pc+2.
- R9: new_sr is cur_sr with bits 30, 29 and 28 forced to 1 and all other bits copied.
- R10: When several requests are present, a fixed priority picks the winner: TLB miss, then address error, then illegal or slot-illegal, then FPU disabled, then trap.
- R11: ent_done is high for exactly the cycle after each cycle that holds a valid request. In any cycle without an entry, all saved and computed outputs keep their previous values.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cur_pc | input | 32 | PC of the faulting instruction |
| cur_sr | input | 32 | Current status register |
| cur_r15 | input | 32 | Current general register 15 |
| vbr | input | 32 | Vector base address |
| in_slot | input | 1 | Instruction sits in a branch delay slot |
| priv_mode | input | 1 | Core is in privileged mode |
| fpu_en | input | 1 | FPU enabled |
| req_undef | input | 1 | Undefined opcode decoded |
| req_priv_op | input | 1 | Privileged opcode decoded |
| req_fpu_op | input | 1 | FPU opcode decoded |
| acc_valid | input | 1 | Data access issued |
| acc_wr | input | 1 | Access is a write |
| acc_long | input | 1 | Access is 32-bit (else 16-bit) |
| acc_off | input | 2 | Low address bits of the access |
| req_trap | input | 1 | Trap instruction decoded |
| trap_imm | input | 8 | Trap immediate |
| req_tlb | input | 1 | TLB miss reported |
| tlb_code | input | 12 | Event code for the TLB miss |
| ent_done | output | 1 | Entry performed (one-cycle pulse) |
| slot_clr | output | 1 | Clear the delay-slot flag |
| saved_pc | output | 32 | PC to save |
| saved_sr | output | 32 | Status to save |
| saved_r15 | output | 32 | R15 to save |
| evt_code | output | 12 | Exception event code |
| new_pc | output | 32 | Handler address |
| next_pc | output | 32 | Fetch address after the handler's first instruction |
| new_sr | output | 32 | Status word for the handler |
| trap_val | output | 32 | Trap register value |

## Verification
Each cause is first applied on its own, both outside and inside a delay slot. This separates the normal and slot event codes and the two saved-PC adjustments. The qualified requests are tried with their enable condition both met and not met: privileged opcodes with and without privilege, FPU opcodes with the FPU enabled and disabled, and accesses of each size with aligned and misaligned offsets. These runs show that only real faults cause an entry. Requests are then stacked in shrinking sets so that each rank of the priority order wins once. Idle cycles between entries show that outputs hold and that the done pulse lasts one cycle. A behavioural model is compared against every output on every clock.

// File: rtl/exc_entry_pkg.sv
package exc_entry_pkg;
  parameter int XLEN   = 32;
  parameter int CODE_W = 12;
  parameter int IMM_W  = 8;

  localparam logic [CODE_W-1:0] CODE_RD_ADDR  = 12'h0E0;
  localparam logic [CODE_W-1:0] CODE_WR_ADDR  = 12'h100;
  localparam logic [CODE_W-1:0] CODE_TRAP     = 12'h160;
  localparam logic [CODE_W-1:0] CODE_ILL      = 12'h180;
  localparam logic [CODE_W-1:0] CODE_SLOT_ILL = 12'h1A0;
  localparam logic [CODE_W-1:0] CODE_FPU      = 12'h800;
  localparam logic [CODE_W-1:0] CODE_SLOT_FPU = 12'h820;

  localparam logic [XLEN-1:0] VEC_GENERAL = 32'h0000_0100;
  localparam logic [XLEN-1:0] VEC_TLB     = 32'h0000_0400;
  localparam logic [XLEN-1:0] INSN_BYTES  = 32'd2;

  localparam int SR_MODE_BIT  = 30;
  localparam int SR_BANK_BIT  = 29;
  localparam int SR_BLOCK_BIT = 28;

  typedef enum logic [2:0] {
    CAUSE_NONE, CAUSE_TLB, CAUSE_ADDR, CAUSE_ILL, CAUSE_FPU, CAUSE_TRAP
  } cause_e;

  function automatic logic [XLEN-1:0] handler_addr(input logic [XLEN-1:0] base,
                                                   input logic is_tlb);
    return base + (is_tlb ? VEC_TLB : VEC_GENERAL);
  endfunction

  function automatic logic [XLEN-1:0] handler_sr(input logic [XLEN-1:0] sr);
    logic [XLEN-1:0] r;
    r = sr;
    r[SR_MODE_BIT]  = 1'b1;
    r[SR_BANK_BIT]  = 1'b1;
    r[SR_BLOCK_BIT] = 1'b1;
    return r;
  endfunction

  function automatic logic [XLEN-1:0] return_pc(input logic [XLEN-1:0] pc,
                                                input logic slot, input logic trap);
    logic [XLEN-1:0] r;
    r = pc;
    if (trap) r = r + INSN_BYTES;
    if (slot) r = r - INSN_BYTES;
    return r;
  endfunction
endpackage

// File: rtl/exc_align_chk.sv
module exc_align_chk #(
  parameter int OFF_W = 2
) (
  input  logic             acc_valid,
  input  logic             acc_wr,
  input  logic             acc_long,
  input  logic [OFF_W-1:0] acc_off,
  output logic             rd_err,
  output logic             wr_err
);
  logic mis;
  always_comb begin
    if (acc_long) mis = |acc_off;
    else          mis = acc_off[0];
  end
  assign rd_err = acc_valid & mis & ~acc_wr;
  assign wr_err = acc_valid & mis & acc_wr;
endmodule

// File: rtl/exc_cause_sel.sv
module exc_cause_sel
  import exc_entry_pkg::*;
(
  input  logic              in_slot,
  input  logic              priv_mode,
  input  logic              fpu_en,
  input  logic              req_undef,
  input  logic              req_priv_op,
  input  logic              req_fpu_op,
  input  logic              req_trap,
  input  logic              req_tlb,
  input  logic [CODE_W-1:0] tlb_code,
  input  logic              rd_err,
  input  logic              wr_err,
  output cause_e            cause,
  output logic [CODE_W-1:0] code
);
  logic ill_hit, fpu_hit, trap_hit;
  assign ill_hit  = req_undef | (req_priv_op & ~priv_mode) | (req_trap & in_slot);
  assign fpu_hit  = req_fpu_op & ~fpu_en;
  assign trap_hit = req_trap & ~in_slot;

  always_comb begin
    cause = CAUSE_NONE;
    code  = '0;
    if (req_tlb) begin
      cause = CAUSE_TLB;
      code  = tlb_code;
    end else if (rd_err | wr_err) begin
      cause = CAUSE_ADDR;
      code  = wr_err ? CODE_WR_ADDR : CODE_RD_ADDR;
    end else if (ill_hit) begin
      cause = CAUSE_ILL;
      code  = in_slot ? CODE_SLOT_ILL : CODE_ILL;
    end else if (fpu_hit) begin
      cause = CAUSE_FPU;
      code  = in_slot ? CODE_SLOT_FPU : CODE_FPU;
    end else if (trap_hit) begin
      cause = CAUSE_TRAP;
      code  = CODE_TRAP;
    end
  end
endmodule

// File: rtl/exc_entry_ctrl.sv
module exc_entry_ctrl
  import exc_entry_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [XLEN-1:0]   cur_pc,
  input  logic [XLEN-1:0]   cur_sr,
  input  logic [XLEN-1:0]   cur_r15,
  input  logic [XLEN-1:0]   vbr,
  input  logic              in_slot,
  input  logic              priv_mode,
  input  logic              fpu_en,
  input  logic              req_undef,
  input  logic              req_priv_op,
  input  logic              req_fpu_op,
  input  logic              acc_valid,
  input  logic              acc_wr,
  input  logic              acc_long,
  input  logic [1:0]        acc_off,
  input  logic              req_trap,
  input  logic [IMM_W-1:0]  trap_imm,
  input  logic              req_tlb,
  input  logic [CODE_W-1:0] tlb_code,
  output logic              ent_done,
  output logic              slot_clr,
  output logic [XLEN-1:0]   saved_pc,
  output logic [XLEN-1:0]   saved_sr,
  output logic [XLEN-1:0]   saved_r15,
  output logic [CODE_W-1:0] evt_code,
  output logic [XLEN-1:0]   new_pc,
  output logic [XLEN-1:0]   next_pc,
  output logic [XLEN-1:0]   new_sr,
  output logic [XLEN-1:0]   trap_val
);
  localparam int PAD_W = XLEN - IMM_W - 2;

  logic              rd_err, wr_err;
  cause_e            cause;
  logic [CODE_W-1:0] code;
  logic              take, is_tlb, is_trap;
  logic [XLEN-1:0]   target;

  exc_align_chk #(.OFF_W(2)) u_align (
    .acc_valid(acc_valid), .acc_wr(acc_wr), .acc_long(acc_long),
    .acc_off(acc_off), .rd_err(rd_err), .wr_err(wr_err)
  );

  exc_cause_sel u_sel (
    .in_slot(in_slot), .priv_mode(priv_mode), .fpu_en(fpu_en),
    .req_undef(req_undef), .req_priv_op(req_priv_op), .req_fpu_op(req_fpu_op),
    .req_trap(req_trap), .req_tlb(req_tlb), .tlb_code(tlb_code),
    .rd_err(rd_err), .wr_err(wr_err), .cause(cause), .code(code)
  );

  assign take    = (cause != CAUSE_NONE);
  assign is_tlb  = (cause == CAUSE_TLB);
  assign is_trap = (cause == CAUSE_TRAP);
  assign target  = handler_addr(vbr, is_tlb);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      ent_done  <= 1'b0;
      slot_clr  <= 1'b0;
      saved_pc  <= '0;
      saved_sr  <= '0;
      saved_r15 <= '0;
      evt_code  <= '0;
      new_pc    <= '0;
      next_pc   <= '0;
      new_sr    <= '0;
      trap_val  <= '0;
    end else begin
      ent_done <= take;
      slot_clr <= take & in_slot;
      if (take) begin
        saved_pc  <= return_pc(cur_pc, in_slot, is_trap);
        saved_sr  <= cur_sr;
        saved_r15 <= cur_r15;
        evt_code  <= code;
        new_pc    <= target;
        next_pc   <= target + INSN_BYTES;
        new_sr    <= handler_sr(cur_sr);
      end
      if (is_trap) trap_val <= {{PAD_W{1'b0}}, trap_imm, 2'b00};
    end
  end
endmodule

// File: rtl/exc_entry_chk.sv
module exc_entry_chk
  import exc_entry_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic [XLEN-1:0]   cur_r15,
  input logic [IMM_W-1:0]  trap_imm,
  input logic              ent_done,
  input logic              slot_clr,
  input logic [XLEN-1:0]   saved_pc,
  input logic [XLEN-1:0]   saved_r15,
  input logic [CODE_W-1:0] evt_code,
  input logic [XLEN-1:0]   new_pc,
  input logic [XLEN-1:0]   next_pc,
  input logic [XLEN-1:0]   new_sr,
  input logic [XLEN-1:0]   trap_val
);
  // R9
  mode_bits_set_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_done |-> (new_sr[SR_MODE_BIT] && new_sr[SR_BANK_BIT] && new_sr[SR_BLOCK_BIT]));
  // R8
  fetch_follows_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_done |-> (next_pc == new_pc + INSN_BYTES));
  // R3
  slot_clear_pair_chk: assert property (@(posedge clk) disable iff (!rst_n)
    slot_clr |-> ent_done);
  // R2
  r15_saved_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ent_done |-> (saved_r15 == $past(cur_r15)));
  // R11
  pc_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_done |-> $stable(saved_pc));
  // R11
  code_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !ent_done |-> $stable(evt_code));
  // R7
  trap_value_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ent_done && evt_code == CODE_TRAP) |-> (trap_val == {{(XLEN-IMM_W-2){1'b0}}, $past(trap_imm), 2'b00}));
endmodule

bind exc_entry_ctrl exc_entry_chk u_chk (
  .clk(clk), .rst_n(rst_n), .cur_r15(cur_r15), .trap_imm(trap_imm),
  .ent_done(ent_done), .slot_clr(slot_clr), .saved_pc(saved_pc),
  .saved_r15(saved_r15), .evt_code(evt_code), .new_pc(new_pc),
  .next_pc(next_pc), .new_sr(new_sr), .trap_val(trap_val)
);

// File: tb/exc_entry_ctrl_test.sv
`timescale 1ns/1ps
module exc_entry_ctrl_test;
  logic        clk = 0, rst_n = 0;
  logic [31:0] cur_pc, cur_sr, cur_r15, vbr;
  logic        in_slot, priv_mode, fpu_en, req_undef, req_priv_op, req_fpu_op;
  logic        acc_valid, acc_wr, acc_long, req_trap, req_tlb;
  logic [1:0]  acc_off;
  logic [7:0]  trap_imm;
  logic [11:0] tlb_code;
  logic        ent_done, slot_clr;
  logic [31:0] saved_pc, saved_sr, saved_r15, new_pc, next_pc, new_sr, trap_val;
  logic [11:0] evt_code;

  int total = 0, bad = 0;
  logic        e_done, e_slot;
  logic [31:0] e_spc, e_ssr, e_r15, e_npc, e_fpc, e_nsr, e_tv;
  logic [11:0] e_code;

  always #5 clk = ~clk;

  exc_entry_ctrl uut (.*);

  task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // behavioural reference model
  always @(posedge clk) begin
    if (!rst_n) begin
      e_done = 0; e_slot = 0; e_spc = 0; e_ssr = 0; e_r15 = 0;
      e_npc = 0; e_fpc = 0; e_nsr = 0; e_tv = 0; e_code = 0;
    end else begin
      bit mis, hit, tlb, trp;
      int code;
      mis  = acc_valid && (acc_long ? (acc_off != 0) : acc_off[0]);
      hit = 1; tlb = 0; trp = 0;
      if (req_tlb) begin code = tlb_code; tlb = 1; end
      else if (mis) code = acc_wr ? 'h100 : 'h0E0;
      else if (req_undef || (req_priv_op && !priv_mode) || (req_trap && in_slot))
        code = in_slot ? 'h1A0 : 'h180;
      else if (req_fpu_op && !fpu_en) code = in_slot ? 'h820 : 'h800;
      else if (req_trap) begin code = 'h160; trp = 1; end
      else begin hit = 0; code = 0; end
      e_done = hit;
      e_slot = hit && in_slot;
      if (hit) begin
        e_spc  = cur_pc + (trp ? 2 : 0) - (in_slot ? 2 : 0);
        e_ssr  = cur_sr;
        e_r15  = cur_r15;
        e_code = code[11:0];
        e_npc  = vbr + (tlb ? 32'h400 : 32'h100);
        e_fpc  = e_npc + 2;
        e_nsr  = cur_sr | 32'h7000_0000;
        if (trp) e_tv = {22'd0, trap_imm, 2'b00};
      end
    end
  end

  always @(negedge clk) begin
    chk("R11 ent_done", {31'd0, ent_done}, {31'd0, e_done});
    chk("R3 slot_clr", {31'd0, slot_clr}, {31'd0, e_slot});
    chk("R2 saved_pc", saved_pc, e_spc);
    chk("R2 saved_sr", saved_sr, e_ssr);
    chk("R2 saved_r15", saved_r15, e_r15);
    chk("R4 evt_code", {20'd0, evt_code}, {20'd0, e_code});
    chk("R8 new_pc", new_pc, e_npc);
    chk("R8 next_pc", next_pc, e_fpc);
    chk("R9 new_sr", new_sr, e_nsr);
    chk("R7 trap_val", trap_val, e_tv);
  end

  task automatic idle();
    in_slot = 0; req_undef = 0; req_priv_op = 0; req_fpu_op = 0;
    acc_valid = 0; acc_wr = 0; acc_long = 0; acc_off = 0;
    req_trap = 0; req_tlb = 0;
  endtask

  task automatic step();
    @(negedge clk);
    #1;
  endtask

  initial begin
    #1_000_000;
    bad++;
    $display("FAIL watchdog act=hung exp=finished");
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end

  initial begin
    idle();
    cur_pc = 32'h8C00_1000; cur_sr = 32'h0000_00F0; cur_r15 = 32'h1234_5678;
    vbr = 32'h8C00_0000; priv_mode = 1; fpu_en = 1; trap_imm = 0; tlb_code = 12'h040;
    step(); step();
    // R1 reset state
    chk("R1 done", {31'd0, ent_done}, 0);
    chk("R1 new_pc", new_pc, 0);
    rst_n = 1;
    step();
    chk("R1 after release", saved_pc, 0);

    req_undef = 1; step(); idle();
    chk("R4 undef code", {20'd0, evt_code}, 32'h180);
    chk("R2 saved pc", saved_pc, 32'h8C00_1000);
    chk("R9 sr", new_sr, 32'h7000_00F0);
    step();
    chk("R11 done drops", {31'd0, ent_done}, 0);
    chk("R11 hold", saved_pc, 32'h8C00_1000);

    cur_pc = 32'h8C00_2002; in_slot = 1; req_undef = 1; step(); idle();
    chk("R3 slot ill", {20'd0, evt_code}, 32'h1A0);
    chk("R3 pc back", saved_pc, 32'h8C00_2000);
    chk("R3 clear", {31'd0, slot_clr}, 1);

    req_priv_op = 1; step(); idle();
    chk("R4 priv ok no entry", {31'd0, ent_done}, 0);
    priv_mode = 0; req_priv_op = 1; step(); idle();
    chk("R4 priv fault", {20'd0, evt_code}, 32'h180);
    priv_mode = 1;

    req_fpu_op = 1; step(); idle();
    chk("R5 fpu enabled", {31'd0, ent_done}, 0);
    fpu_en = 0; req_fpu_op = 1; step(); idle();
    chk("R5 fpu off", {20'd0, evt_code}, 32'h800);
    in_slot = 1; req_fpu_op = 1; step(); idle();
    chk("R5 fpu slot", {20'd0, evt_code}, 32'h820);
    fpu_en = 1;

    acc_valid = 1; acc_off = 2'b01; step(); idle();
    chk("R6 rd16", {20'd0, evt_code}, 32'h0E0);
    acc_valid = 1; acc_long = 1; acc_wr = 1; acc_off = 2'b10; step(); idle();
    chk("R6 wr32", {20'd0, evt_code}, 32'h100);
    acc_valid = 1; acc_off = 2'b10; step(); idle();
    chk("R6 aligned16", {31'd0, ent_done}, 0);
    acc_valid = 1; acc_long = 1; acc_off = 2'b00; step(); idle();
    chk("R6 aligned32", {31'd0, ent_done}, 0);

    cur_pc = 32'h8C00_3000; trap_imm = 8'hA5; req_trap = 1; step(); idle();
    chk("R7 trap code", {20'd0, evt_code}, 32'h160);
    chk("R7 trap val", trap_val, 32'h294);
    chk("R7 trap pc", saved_pc, 32'h8C00_3002);
    trap_imm = 8'h11; in_slot = 1; req_trap = 1; step(); idle();
    chk("R7 trap slot", {20'd0, evt_code}, 32'h1A0);
    chk("R7 trap val held", trap_val, 32'h294);

    cur_sr = 32'h4000_0001; req_tlb = 1; step(); idle();
    chk("R8 tlb vec", new_pc, 32'h8C00_0400);
    chk("R8 tlb code", {20'd0, evt_code}, 32'h040);
    chk("R9 sr keep", new_sr, 32'h7000_0001);

    fpu_en = 0; priv_mode = 0;
    req_tlb = 1; acc_valid = 1; acc_off = 1; req_undef = 1; req_fpu_op = 1; req_trap = 1;
    step();
    chk("R10 tlb wins", {20'd0, evt_code}, 32'h040);
    req_tlb = 0; step();
    chk("R10 addr wins", {20'd0, evt_code}, 32'h0E0);
    acc_valid = 0; step();
    chk("R10 ill wins", {20'd0, evt_code}, 32'h180);
    req_undef = 0; step();
    chk("R10 fpu wins", {20'd0, evt_code}, 32'h800);
    req_fpu_op = 0; trap_imm = 8'h03; step(); idle();
    chk("R10 trap last", {20'd0, evt_code}, 32'h160);
    step(); step();

    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule